// File: doc/BRIEF.md
# Debounced 4x4 Keypad Scanner

This block reads a sixteen-key matrix keypad. The keys are labelled 0 to F. It raises one row line at a time and holds it for a set number of cycles. At the end of that time it reads the column inputs. If any column is active, the block stops scanning and waits a debounce interval. It then reads the same column again on the same row. A contact that has gone away by then is treated as bounce and dropped. A contact that is still there is reported once: the block drives a one-cycle valid pulse together with the row, the column and a 4-bit key code.

After a report, the row stays parked on the key. Scanning starts again only after that column has read inactive for a full debounce interval, so a key that is held down produces a single report. The row dwell time and the debounce length are parameters given in clock cycles. The debounce default matches a few milliseconds at a typical clock; a bench shortens it.

Top module: `keypad_scan`

## Requirements
- R1: While reset is held and in the first cycle after it, row_out has only bit 0 set and key_valid is low.
- R2: Exactly one row_out bit is high at any time. During scanning, row bit i is driven for DWELL_CYC cycles, then bit i+1; after bit ROWS-1 the scan returns to bit 0.
- R3: A key is reported only if its column is still active DEBOUNCE_CYC cycles after it was first seen. A press that lasts fewer than DEBOUNCE_CYC cycles produces no key_valid pulse.
- R4: When several columns read active on the driven row, the lowest-numbered column is the one reported.
- R5: On a report, key_row is the index of the driven row bit and key_col is the index of the active col_in bit. key_code equals key_row*4 + key_col, so key 0 is row 0 column 0 and key F is row 3 column 3.
- R6: key_valid is high for exactly one cycle per report. A key that is held down is reported only once.
- R7: After the reported key has read released for DEBOUNCE_CYC consecutive cycles, scanning resumes, and a later press is reported.
- R8: key_valid rises within ROWS*DWELL_CYC + DEBOUNCE_CYC + 4 cycles of the start of a press that is held long enough.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| col_in | input | 4 | Column sense lines, active high |
| row_out | output | 4 | Row drive lines, active high, one-hot |
| key_valid | output | 1 | One-cycle pulse when a key is accepted |
| key_row | output | 2 | Row of the accepted key |
| key_col | output | 2 | Column of the accepted key |
| key_code | output | 4 | Key code 0 to F |

## Verification
The assertions assume that a column input reads high only while the row it belongs to is driven. They also assume the column lines are synchronous to clk and stay stable across the sampling edge. The bench meets both assumptions with a keypad model that ORs the pressed keys of the driven row onto the column lines, and it changes key state only on falling edges. Random single-key presses are either clearly shorter than the debounce interval or clearly longer than the reporting bound. Each press is followed by an idle gap long enough for the release debounce to finish, so every report can be attributed to one press.

// File: rtl/kps_pkg.sv
package kps_pkg;
    typedef enum logic [1:0] {
        ST_SCAN    = 2'd0,
        ST_CONFIRM = 2'd1,
        ST_RELEASE = 2'd2
    } kps_state_e;
endpackage

// File: rtl/kps_row_drive.sv
module kps_row_drive #(
    parameter int ROWS  = 4,
    parameter int ROW_W = 2
) (
    input  logic [ROW_W-1:0] row_idx,
    output logic [ROWS-1:0]  row_out
);
    for (genvar i = 0; i < ROWS; i++) begin : g_row
        assign row_out[i] = (row_idx == ROW_W'(i));
    end
endmodule

// File: rtl/kps_col_pick.sv
module kps_col_pick #(
    parameter int COLS  = 4,
    parameter int COL_W = 2
) (
    input  logic [COLS-1:0]  cols,
    output logic             any,
    output logic [COL_W-1:0] idx
);
    always_comb begin
        any = |cols;
        idx = '0;
        for (int j = COLS - 1; j >= 0; j--) begin
            if (cols[j]) idx = COL_W'(j);
        end
    end
endmodule

// File: rtl/kps_code_map.sv
module kps_code_map #(
    parameter int ROWS   = 4,
    parameter int COLS   = 4,
    parameter int ROW_W  = 2,
    parameter int COL_W  = 2,
    parameter int CODE_W = 4
) (
    input  logic [ROW_W-1:0]  row,
    input  logic [COL_W-1:0]  col,
    output logic [CODE_W-1:0] code
);
    localparam int N_KEYS = ROWS * COLS;
    localparam int IDX_W  = (N_KEYS > 1) ? $clog2(N_KEYS) : 1;

    logic [CODE_W-1:0] tbl [N_KEYS];
    logic [IDX_W-1:0]  idx;

    for (genvar r = 0; r < ROWS; r++) begin : g_r
        for (genvar c = 0; c < COLS; c++) begin : g_c
            assign tbl[r*COLS + c] = CODE_W'(r*COLS + c);
        end
    end

    assign idx  = IDX_W'(row) * IDX_W'(COLS) + IDX_W'(col);
    assign code = tbl[idx];
endmodule

// File: rtl/keypad_scan.sv
module keypad_scan #(
    parameter int ROWS         = 4,
    parameter int COLS         = 4,
    parameter int DWELL_CYC    = 4,
    parameter int DEBOUNCE_CYC = 50000
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic [COLS-1:0]                  col_in,
    output logic [ROWS-1:0]                  row_out,
    output logic                             key_valid,
    output logic [$clog2(ROWS)-1:0]          key_row,
    output logic [$clog2(COLS)-1:0]          key_col,
    output logic [$clog2(ROWS*COLS)-1:0]     key_code
);
    import kps_pkg::*;

    localparam int ROW_W   = $clog2(ROWS);
    localparam int COL_W   = $clog2(COLS);
    localparam int CODE_W  = $clog2(ROWS * COLS);
    localparam int CNT_MAX = (DEBOUNCE_CYC > DWELL_CYC) ? DEBOUNCE_CYC : DWELL_CYC;
    localparam int CNT_W   = $clog2(CNT_MAX + 1);
    localparam logic [CNT_W-1:0] DWELL_LAST = CNT_W'(DWELL_CYC - 1);
    localparam logic [CNT_W-1:0] DEB_LAST   = CNT_W'(DEBOUNCE_CYC - 1);
    localparam logic [ROW_W-1:0] ROW_LAST   = ROW_W'(ROWS - 1);

    typedef struct packed {
        kps_state_e       st;
        logic [ROW_W-1:0] row;
        logic [CNT_W-1:0] cnt;
        logic [COL_W-1:0] cap_col;
        logic             valid;
        logic [ROW_W-1:0] out_row;
        logic [COL_W-1:0] out_col;
    } kps_regs_t;

    kps_regs_t q, d;

    logic             hit;
    logic [COL_W-1:0] hit_col;
    logic [ROW_W-1:0] next_row;
    logic             held;

    kps_row_drive #(.ROWS(ROWS), .ROW_W(ROW_W)) u_rows (
        .row_idx (q.row),
        .row_out (row_out)
    );

    kps_col_pick #(.COLS(COLS), .COL_W(COL_W)) u_pick (
        .cols (col_in),
        .any  (hit),
        .idx  (hit_col)
    );

    kps_code_map #(
        .ROWS(ROWS), .COLS(COLS), .ROW_W(ROW_W), .COL_W(COL_W), .CODE_W(CODE_W)
    ) u_map (
        .row  (q.out_row),
        .col  (q.out_col),
        .code (key_code)
    );

    assign next_row = (q.row == ROW_LAST) ? '0 : q.row + 1'b1;
    assign held     = col_in[q.cap_col];

    always_comb begin
        d       = q;
        d.valid = 1'b0;
        unique case (q.st)
            ST_SCAN: begin
                if (q.cnt == DWELL_LAST) begin
                    d.cnt = '0;
                    if (hit) begin
                        d.st      = ST_CONFIRM;
                        d.cap_col = hit_col;
                    end else begin
                        d.row = next_row;
                    end
                end else begin
                    d.cnt = q.cnt + 1'b1;
                end
            end
            ST_CONFIRM: begin
                if (q.cnt == DEB_LAST) begin
                    d.cnt = '0;
                    if (held) begin
                        d.valid   = 1'b1;
                        d.out_row = q.row;
                        d.out_col = q.cap_col;
                        d.st      = ST_RELEASE;
                    end else begin
                        d.st  = ST_SCAN;
                        d.row = next_row;
                    end
                end else begin
                    d.cnt = q.cnt + 1'b1;
                end
            end
            ST_RELEASE: begin
                if (held) begin
                    d.cnt = '0;
                end else if (q.cnt == DEB_LAST) begin
                    d.cnt = '0;
                    d.st  = ST_SCAN;
                    d.row = next_row;
                end else begin
                    d.cnt = q.cnt + 1'b1;
                end
            end
            default: begin
                d = '0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign key_valid = q.valid;
    assign key_row   = q.out_row;
    assign key_col   = q.out_col;

    AST_ONE_ROW: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot(row_out)); // R2

    AST_PULSE_SHORT: assert property (@(posedge clk) disable iff (!rst_n)
        key_valid |=> !key_valid); // R6

    AST_CODE_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        key_valid |-> int'(key_code) == int'(key_row) * COLS + int'(key_col)); // R5

    AST_CONFIRMED: assert property (@(posedge clk) disable iff (!rst_n)
        key_valid |-> $past(col_in[q.cap_col])); // R3

    AST_ROW_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st != ST_SCAN && d.st != ST_SCAN) |=> $stable(row_out)); // R6
endmodule

// File: tb/keypad_scan_bench.sv
`timescale 1ns/1ps
module keypad_scan_bench;
    localparam int DW  = 4;
    localparam int DEB = 20;
    localparam int BOUND = 4*DW + DEB + 4;
    localparam int IDLE  = 2*DEB + 4*DW + 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] col_in;
    logic [3:0] row_out;
    logic       key_valid;
    logic [1:0] key_row, key_col;
    logic [3:0] key_code;

    logic [15:0] pressed = '0;
    int checks = 0, errors = 0;
    int cyc = 0, start_cyc = 0;
    int pulses = 0, first_lat = 0;
    logic [3:0] got_code;
    logic [1:0] got_row, got_col;
    logic prev_valid = 1'b0;
    logic mon_en = 1'b0;

    always #2 clk = ~clk;

    keypad_scan #(.DWELL_CYC(DW), .DEBOUNCE_CYC(DEB)) u_keypad_scan (
        .clk(clk), .rst_n(rst_n), .col_in(col_in), .row_out(row_out),
        .key_valid(key_valid), .key_row(key_row), .key_col(key_col),
        .key_code(key_code)
    );

    always_comb begin
        for (int c = 0; c < 4; c++) begin
            col_in[c] = 1'b0;
            for (int r = 0; r < 4; r++)
                if (pressed[r*4+c] && row_out[r]) col_in[c] = 1'b1;
        end
    end

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n && mon_en) begin
            if (key_valid && prev_valid) check(1'b0, "R6 pulse width", 2, 1);
            if (key_valid) begin
                pulses++;
                if (pulses == 1) begin
                    first_lat = cyc - start_cyc;
                    got_code = key_code; got_row = key_row; got_col = key_col;
                end
            end
        end
        prev_valid = key_valid;
    end

    function automatic int model_code(input logic [15:0] m);
        for (int c = 0; c < 4; c++)
            for (int r = 0; r < 4; r++)
                if (m[r*4+c]) return r*4 + c;
        return -1;
    endfunction

    task automatic press(input logic [15:0] m, input int dur, input int exp_n);
        int ec;
        ec = model_code(m);
        pulses = 0;
        start_cyc = cyc;
        pressed = m;
        repeat (dur) @(negedge clk);
        pressed = '0;
        repeat (IDLE) @(negedge clk);
        if (exp_n == 0) begin
            check(pulses == 0, "R3 short press ignored", pulses, 0);
        end else begin
            check(pulses == 1, "R6 one report per press", pulses, 1);
            if (pulses >= 1) begin
                check(int'(got_code) == ec, "R5 key code", got_code, ec);
                check(int'(got_row) == ec / 4, "R5 key row", got_row, ec / 4);
                check(int'(got_col) == ec % 4, "R4 R5 key column", got_col, ec % 4);
                check(first_lat <= BOUND, "R8 latency", first_lat, BOUND);
            end
        end
    endtask

    initial begin
        #(200000 * 4);
        check(1'b0, "watchdog", 0, 1);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int k, dur;
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        check(row_out == 4'b0001, "R1 reset row", row_out, 1);
        check(key_valid == 1'b0, "R1 reset valid", key_valid, 0);
        rst_n = 1'b1;
        for (int n = 0; n < 20; n++) begin
            check(row_out == 4'(1 << ((n / DW) % 4)), "R2 row sequence",
                  row_out, 1 << ((n / DW) % 4));
            @(negedge clk);
        end
        mon_en = 1'b1;
        // R4: two columns on row 2, lowest wins
        press(16'h0001 << 9 | 16'h0001 << 11, 6*DEB, 1);
        // R6: long hold reports once
        press(16'h8000, 12*DEB, 1);
        // R7: press after release is reported again
        press(16'h0001, 4*DEB, 1);
        // R3: press one cycle shorter than debounce
        press(16'h0020, DEB - 1, 0);
        for (int i = 0; i < 30; i++) begin
            k = int'($urandom_range(15, 0));
            if ($urandom_range(3, 0) == 0) begin
                dur = int'($urandom_range(DEB - 1, 1));
                press(16'h0001 << k, dur, 0);
            end else begin
                dur = BOUND + 10 + int'($urandom_range(60, 0));
                press(16'h0001 << k, dur, 1);
            end
        end
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule